// File: doc/BRIEF.md
# Remappable Display RAM Scan Addresser

This block turns the position of the display scan (which panel row and which segment are being driven) into the location to read in a bit-mapped display memory of 132 columns by 64 rows. The memory rows are grouped into eight pages of eight rows each, so a row address is given as a page number and a bit position inside the byte of that page.

Three orientation settings are applied on the way. A segment reversal mirrors the column order. A common reversal mirrors the row order. A 6-bit start line rotates the rows, which scrolls the image vertically. The settings are presented on configuration inputs, and they are latched into a shadow copy only when a frame-start pulse arrives. A change therefore never takes effect partway through a frame. The scan sample that arrives together with the frame-start pulse is the first one to use the new settings.

Each scan sample gives exactly one registered address one clock later, with a valid flag.

Top module: `scan_addr_map`

## Requirements
- R1: After a synchronous active-low reset, `ram_valid` is 0, `ram_col`, `ram_page` and `ram_bit` are 0, and the shadow settings are cleared (no segment reversal, no common reversal, start line 0).
- R2: With segment reversal off, `ram_col` equals the scan column. With segment reversal on, `ram_col` equals 131 minus the scan column.
- R3: With common reversal off, the scan row `r` is used as it is. With common reversal on, it is replaced by 63 − `r`. This happens before the start-line offset is added.
- R4: The RAM row is (possibly mirrored row + start line) mod 64. The sum wraps from 63 back to 0.
- R5: `ram_page` is the RAM row divided by 8, held in bits [5:3]. `ram_bit` is the RAM row mod 8, held in bits [2:0].
- R6: The configuration inputs affect the mapping only through the shadow settings. The shadow settings load only in a cycle with `frame_start` high. A sample presented in that same cycle already uses the new values. Changes made without `frame_start` have no effect on the output.
- R7: A sample taken while `scan_valid` is high gives its result on the outputs one clock edge later. `ram_valid` is then 1 when the scan column is below 132, and 0 when the column is 132 or more.
- R8: In a cycle with `scan_valid` low, `ram_valid` becomes 0 at the next edge, and `ram_col`, `ram_page` and `ram_bit` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_seg_flip | input | 1 | Requested segment (column) reversal |
| cfg_com_flip | input | 1 | Requested common (row) reversal |
| cfg_start_line | input | 6 | Requested display start line |
| frame_start | input | 1 | Loads the requested settings into the shadow copy |
| scan_valid | input | 1 | Scan sample present this cycle |
| scan_row | input | 6 | Display row being scanned |
| scan_col | input | 8 | Segment being scanned |
| ram_valid | output | 1 | Registered address is valid |
| ram_col | output | 8 | RAM column to read |
| ram_page | output | 3 | RAM page to read |
| ram_bit | output | 3 | Bit position within the page byte |

## Verification
Every address result, and the valid flag, is due exactly one rising edge after the sample is presented. The frame-start load reaches the shadow settings at that same edge. The bench drives each sample on a falling edge and reads the outputs 5 ns after the following rising edge, so it compares the value captured at that one edge and nothing later. Its reference model updates its shadow copy of the settings only for vectors that carry `frame_start`, which makes stale settings visible in the output. For idle cycles the expected addresses are the previous expected ones.

// File: rtl/scanmap_pkg.sv
// Package: scanmap_pkg
// Shared types for the scan addresser: the orientation flags kept
// together as a pair. Assumes the flags are independent of each other.
package scanmap_pkg;

    typedef struct packed {
        logic seg_flip;   // mirror column order
        logic com_flip;   // mirror row order
    } orient_t;

endpackage

// File: rtl/scanmap_cfg_shadow.sv
// Module: scanmap_cfg_shadow
// Holds the per-frame copy of the orientation and start-line settings.
// The copy loads only on frame_start. While frame_start is high, the
// active outputs pass the requested values through, so the first sample
// of the new frame already uses them.
// Assumes frame_start is a one-cycle pulse at the frame boundary.
module scanmap_cfg_shadow
    import scanmap_pkg::*;
#(
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  orient_t          orient_req,
    input  logic [ROW_W-1:0] start_req,
    output orient_t          orient_act,
    output logic [ROW_W-1:0] start_act
);

    orient_t          orient_q;
    logic [ROW_W-1:0] start_q;

    // Capture the requested settings at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            orient_q <= '0;
            start_q  <= '0;
        end else if (frame_start) begin
            orient_q <= orient_req;
            start_q  <= start_req;
        end
    end

    // Pick the settings that govern this cycle's sample.
    always_comb begin
        if (frame_start) begin
            orient_act = orient_req;
            start_act  = start_req;
        end else begin
            orient_act = orient_q;
            start_act  = start_q;
        end
    end

endmodule

// File: rtl/scanmap_row_mapper.sv
// Module: scanmap_row_mapper
// Converts a scan row into a RAM page and bit position. It mirrors the
// row first when requested, then adds the start line modulo the row count.
// Assumes NUM_ROWS and ROWS_PER_PAGE are powers of two and
// ROWS_PER_PAGE >= 2, so the modulo is a plain wrap of the adder and the
// split is a bit slice.
module scanmap_row_mapper #(
    parameter int NUM_ROWS      = 64,
    parameter int ROWS_PER_PAGE = 8,
    localparam int ROW_W  = $clog2(NUM_ROWS),
    localparam int BIT_W  = $clog2(ROWS_PER_PAGE),
    localparam int PAGE_W = ROW_W - BIT_W
) (
    input  logic              com_flip,
    input  logic [ROW_W-1:0]  start_line,
    input  logic [ROW_W-1:0]  scan_row,
    output logic [PAGE_W-1:0] page,
    output logic [BIT_W-1:0]  bit_idx
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    logic [ROW_W-1:0] oriented_row;
    logic [ROW_W-1:0] ram_row;

    // Apply the optional row reversal before the scroll offset.
    always_comb begin
        oriented_row = com_flip ? (LAST_ROW - scan_row) : scan_row;
    end

    // Add the start line; the adder width gives the modulo wrap.
    always_comb begin
        ram_row = oriented_row + start_line;
    end

    // Split the RAM row into page number and bit within the page.
    always_comb begin
        page    = ram_row[ROW_W-1:BIT_W];
        bit_idx = ram_row[BIT_W-1:0];
    end

endmodule

// File: rtl/scanmap_col_mapper.sv
// Module: scanmap_col_mapper
// Converts a scan segment index into a RAM column and applies the
// optional column reversal. It also flags indices beyond the last column.
// When NUM_COLS fills the index width, the range check is left out.
module scanmap_col_mapper #(
    parameter int NUM_COLS = 132,
    localparam int COL_W = $clog2(NUM_COLS)
) (
    input  logic             seg_flip,
    input  logic [COL_W-1:0] scan_col,
    output logic [COL_W-1:0] ram_col,
    output logic             in_range
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    // Mirror the column order when reversal is selected.
    always_comb begin
        ram_col = seg_flip ? (LAST_COL - scan_col) : scan_col;
    end

    generate
        if (NUM_COLS == (1 << COL_W)) begin : g_full_range
            // Every index names a real column.
            always_comb begin
                in_range = 1'b1;
            end
        end else begin : g_partial_range
            // Indices above the last column are rejected.
            always_comb begin
                in_range = (scan_col <= LAST_COL);
            end
        end
    endgenerate

endmodule

// File: rtl/scan_addr_map.sv
// Module: scan_addr_map (top)
// Scan-position-to-RAM-address mapper for a paged, bit-mapped display
// memory. It combines the frame-latched orientation settings with the row
// and column mappers, then registers the address once. Latency is one clock.
// Assumes the scan counters are generated outside this block.
module scan_addr_map
    import scanmap_pkg::*;
#(
    parameter int NUM_COLS      = 132,
    parameter int NUM_ROWS      = 64,
    parameter int ROWS_PER_PAGE = 8,
    localparam int COL_W  = $clog2(NUM_COLS),
    localparam int ROW_W  = $clog2(NUM_ROWS),
    localparam int BIT_W  = $clog2(ROWS_PER_PAGE),
    localparam int PAGE_W = ROW_W - BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_seg_flip,
    input  logic              cfg_com_flip,
    input  logic [ROW_W-1:0]  cfg_start_line,
    input  logic              frame_start,
    input  logic              scan_valid,
    input  logic [ROW_W-1:0]  scan_row,
    input  logic [COL_W-1:0]  scan_col,
    output logic              ram_valid,
    output logic [COL_W-1:0]  ram_col,
    output logic [PAGE_W-1:0] ram_page,
    output logic [BIT_W-1:0]  ram_bit
);

    orient_t           orient_req;
    orient_t           orient_act;
    logic [ROW_W-1:0]  start_act;
    logic [COL_W-1:0]  col_map;
    logic              col_ok;
    logic [PAGE_W-1:0] page_map;
    logic [BIT_W-1:0]  bit_map;

    // Gather the requested orientation flags into one struct.
    always_comb begin
        orient_req.seg_flip = cfg_seg_flip;
        orient_req.com_flip = cfg_com_flip;
    end

    scanmap_cfg_shadow #(
        .ROW_W (ROW_W)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .orient_req  (orient_req),
        .start_req   (cfg_start_line),
        .orient_act  (orient_act),
        .start_act   (start_act)
    );

    scanmap_row_mapper #(
        .NUM_ROWS      (NUM_ROWS),
        .ROWS_PER_PAGE (ROWS_PER_PAGE)
    ) u_rows (
        .com_flip   (orient_act.com_flip),
        .start_line (start_act),
        .scan_row   (scan_row),
        .page       (page_map),
        .bit_idx    (bit_map)
    );

    scanmap_col_mapper #(
        .NUM_COLS (NUM_COLS)
    ) u_cols (
        .seg_flip (orient_act.seg_flip),
        .scan_col (scan_col),
        .ram_col  (col_map),
        .in_range (col_ok)
    );

    // Register the mapped address; on idle cycles hold it and drop valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_valid <= 1'b0;
            ram_col   <= '0;
            ram_page  <= '0;
            ram_bit   <= '0;
        end else if (scan_valid) begin
            ram_valid <= col_ok;
            ram_col   <= col_map;
            ram_page  <= page_map;
            ram_bit   <= bit_map;
        end else begin
            ram_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/scan_addr_map_chk.sv
// Module: scan_addr_map_chk
// Checker bound to scan_addr_map. It relates the scan inputs and the
// active settings to the registered outputs one cycle later.
module scan_addr_map_chk #(
    parameter int NUM_COLS = 132,
    parameter int COL_W    = 8,
    parameter int ROW_W    = 6,
    parameter int PAGE_W   = 3,
    parameter int BIT_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_valid,
    input logic [COL_W-1:0]  scan_col,
    input logic              seg_act,
    input logic              ram_valid,
    input logic [COL_W-1:0]  ram_col,
    input logic [PAGE_W-1:0] ram_page,
    input logic [BIT_W-1:0]  ram_bit
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    // R7
    in_range_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_col <= LAST_COL) |=> ram_valid);

    // R7
    out_range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_col > LAST_COL) |=> !ram_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_valid |=> (!ram_valid && $stable(ram_col) && $stable(ram_page) && $stable(ram_bit)));

    // R2
    col_straight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !seg_act) |=> (ram_col == $past(scan_col)));

    // R2
    col_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && seg_act && scan_col <= LAST_COL) |=> (ram_col == LAST_COL - $past(scan_col)));

endmodule

bind scan_addr_map scan_addr_map_chk #(
    .NUM_COLS (NUM_COLS),
    .COL_W    (COL_W),
    .ROW_W    (ROW_W),
    .PAGE_W   (PAGE_W),
    .BIT_W    (BIT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_valid (scan_valid),
    .scan_col   (scan_col),
    .seg_act    (orient_act.seg_flip),
    .ram_valid  (ram_valid),
    .ram_col    (ram_col),
    .ram_page   (ram_page),
    .ram_bit    (ram_bit)
);

// File: tb/sim_scan_addr_map.sv
// Bench for scan_addr_map: directed corners plus seeded random vectors,
// compared with a reference model built from the requirements.
module sim_scan_addr_map;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_seg_flip = 1'b0;
    logic       cfg_com_flip = 1'b0;
    logic [5:0] cfg_start_line = '0;
    logic       frame_start = 1'b0;
    logic       scan_valid = 1'b0;
    logic [5:0] scan_row = '0;
    logic [7:0] scan_col = '0;
    logic       ram_valid;
    logic [7:0] ram_col;
    logic [2:0] ram_page;
    logic [2:0] ram_bit;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // model state
    bit       m_seg = 1'b0;
    bit       m_com = 1'b0;
    bit [5:0] m_start = '0;
    bit [7:0] e_col = '0;
    bit [2:0] e_page = '0;
    bit [2:0] e_bit = '0;
    bit       e_valid = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    scan_addr_map u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_seg_flip   (cfg_seg_flip),
        .cfg_com_flip   (cfg_com_flip),
        .cfg_start_line (cfg_start_line),
        .frame_start    (frame_start),
        .scan_valid     (scan_valid),
        .scan_row       (scan_row),
        .scan_col       (scan_col),
        .ram_valid      (ram_valid),
        .ram_col        (ram_col),
        .ram_page       (ram_page),
        .ram_bit        (ram_bit)
    );

    // R2: column mirror about 131
    function automatic bit [7:0] f_col(bit seg, bit [7:0] c);
        return seg ? 8'(131 - int'(c)) : c;
    endfunction

    // R3 then R4: mirror about 63, then add the start line mod 64
    function automatic bit [5:0] f_row(bit com, bit [5:0] st, bit [5:0] r);
        int rr;
        rr = com ? (63 - int'(r)) : int'(r);
        return 6'((rr + int'(st)) % 64);
    endfunction

    task automatic check(string req);
        vectors++;
        if (ram_valid !== e_valid || ram_col !== e_col ||
            ram_page !== e_page || ram_bit !== e_bit) begin
            fails++;
            $display("FAIL %s: got v=%0b col=%0d page=%0d bit=%0d, want v=%0b col=%0d page=%0d bit=%0d",
                     req, ram_valid, ram_col, ram_page, ram_bit,
                     e_valid, e_col, e_page, e_bit);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, check after the next rising edge.
    task automatic step(bit v, bit [5:0] r, bit [7:0] c, bit fs,
                        bit seg, bit com, bit [5:0] st, string req);
        bit [5:0] rr;
        @(negedge clk);
        scan_valid = v; scan_row = r; scan_col = c; frame_start = fs;
        cfg_seg_flip = seg; cfg_com_flip = com; cfg_start_line = st;
        if (fs) begin m_seg = seg; m_com = com; m_start = st; end   // R6
        if (v) begin
            rr      = f_row(m_com, m_start, r);
            e_col   = f_col(m_seg, c);
            e_page  = rr[5:3];                                      // R5
            e_bit   = rr[2:0];
            e_valid = (c < 8'd132);                                 // R7
        end else begin
            e_valid = 1'b0;                                         // R8
        end
        @(posedge clk);
        #5;
        check(req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset outputs");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: shadow cleared -> identity mapping with no frame_start
        step(1, 6'd13, 8'd40, 0, 1, 1, 6'd9, "R1 cleared shadow");
        // R2 corners
        step(1, 6'd0, 8'd0,   1, 1, 0, 6'd0, "R2 mirror col 0");
        step(1, 6'd0, 8'd131, 0, 1, 0, 6'd0, "R2 mirror col 131");
        step(1, 6'd0, 8'd131, 1, 0, 0, 6'd0, "R2 straight col 131");
        // R7 range
        step(1, 6'd5, 8'd132, 0, 0, 0, 6'd0, "R7 col 132 rejected");
        step(1, 6'd5, 8'd255, 0, 0, 0, 6'd0, "R7 col 255 rejected");
        // R3 mirror row
        step(1, 6'd0,  8'd1, 1, 0, 1, 6'd0, "R3 row 0 mirrored");
        step(1, 6'd63, 8'd1, 0, 0, 1, 6'd0, "R3 row 63 mirrored");
        // R4 wrap
        step(1, 6'd63, 8'd2, 1, 0, 0, 6'd63, "R4 wrap 63+63");
        step(1, 6'd1,  8'd2, 0, 0, 0, 6'd63, "R4 wrap 1+63");
        // R3 then R4 order
        step(1, 6'd10, 8'd3, 1, 0, 1, 6'd5, "R3 R4 order");
        // R5 page/bit split
        step(1, 6'd43, 8'd4, 1, 0, 0, 6'd0, "R5 split row 43");
        // R6 ignored without frame_start, then seen output
        step(1, 6'd7, 8'd20, 0, 1, 1, 6'd30, "R6 change ignored");
        step(1, 6'd7, 8'd20, 1, 1, 1, 6'd30, "R6 change applied");
        // R8 idle hold
        step(0, 6'd50, 8'd99, 0, 0, 0, 6'd0, "R8 idle hold");
        step(0, 6'd51, 8'd98, 0, 1, 0, 6'd2, "R8 idle hold again");
        // random mix
        for (int i = 0; i < 400; i++) begin
            bit v, fs, seg, com;
            bit [5:0] r, st;
            bit [7:0] c;
            v   = ($urandom % 8) != 0;
            fs  = ($urandom % 16) == 0;
            seg = 1'($urandom);
            com = 1'($urandom);
            st  = 6'($urandom);
            r   = 6'($urandom);
            c   = (($urandom % 10) == 0) ? 8'(132 + $urandom % 124) : 8'($urandom % 132);
            step(v, r, c, fs, seg, com, st, "R2 R3 R4 R5 R6 R7 R8 random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule